// File: doc/BRIEF.md
# Level-Sensitive Interrupt State Controller

This block keeps a three-way state (idle, waiting for service, in service) for each of a parameterised number of peripheral interrupt lines, 41 by default. A line becomes waiting when its input is seen high while it is not in service, when a low-to-high transition is seen on it, or when software raises it with a set strobe. A software clear strobe only takes effect when the line is low. A line that is still high stays waiting.

The block compares every waiting, enabled line that is not in service, using a 4-bit urgency value per line in which a smaller number is more urgent. It offers the winner to the processor through a request valid/index pair. The request is raised only when the winner would preempt the handler that is running now. The processor signals handler entry with an acknowledge that carries the accepted index, and it signals handler exit with a single return strobe. On exit the line is sampled again, so a peripheral that still drives its line high is served again.

Top module: `irq_level_ctrl`

## Requirements
- R1: A synchronous active-high reset, sampled on a rising clock edge, returns every line to idle (pending and active both 0) and clears the request valid output.
- R2: A line sampled high at a clock edge, while it is not active after that edge, shows pending after that edge.
- R3: A line that is low at one edge and high at the next becomes pending, whether or not it is active. Once latched, the pending bit stays set after the line falls, until entry or a clear succeeds.
- R4: A software set strobe makes its line pending at the next edge. When a set strobe and a clear strobe reach the same line in the same cycle, the set wins.
- R5: A software clear strobe returns a pending line to not-pending at the next edge only if the line is low at that edge. While the line is high, the clear has no effect.
- R6: An acknowledge with index k makes line k active and not pending at the next edge.
- R7: On a return strobe, the running line leaves the active state at the next edge. The running line is the active line with the smallest priority value, and the lowest index if two are equal. If that line is high at the edge, it becomes pending again at once; otherwise it becomes idle.
- R8: The request index is the line with the smallest priority value among lines that are pending, enabled and not active. Equal values go to the lowest index.
- R9: Request valid is high only when the winner's priority value is strictly smaller than the current level. The current level is the smallest priority value among active lines, or 16 when no line is active.
- R10: A pending line whose enable bit is 0 never produces a request, and it keeps its pending state.
- R11: The request outputs follow the registered state, the enable bits and the priorities without an extra register. A change of priority or enable shows on the request within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_line | input | N_IRQ | Raw interrupt line levels |
| irq_en | input | N_IRQ | Per-line enable |
| irq_prio | input | 4*N_IRQ | Per-line priority, line i in bits [4i+3:4i], 0 most urgent |
| sw_set | input | N_IRQ | Software set-pending strobes |
| sw_clr | input | N_IRQ | Software clear-pending strobes |
| ack_valid | input | 1 | Handler entry acknowledge |
| ack_idx | input | $clog2(N_IRQ) | Index of the line being entered |
| ret_valid | input | 1 | Handler return strobe |
| req_valid | output | 1 | A line is offered for preemption |
| req_idx | output | $clog2(N_IRQ) | Index of the offered line |
| pend_o | output | N_IRQ | Per-line pending state |
| act_o | output | N_IRQ | Per-line active state |

## Verification
Any pending or active change caused by a line level, an edge, a strobe, an acknowledge or a return shows after exactly one rising edge. The request outputs are combinational on that state, so they update in the same cycle as the state. A new enable or priority value changes the request with no edge at all. The bench drives inputs on the falling edge and steps its reference model across the following rising edge. It compares all outputs at the next falling edge, and it checks priority and enable effects a short delay after the change, before any edge has passed.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int PRIO_W = 4;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [PRIO_W:0]   level_t;

    localparam level_t LEVEL_IDLE = level_t'(1 << PRIO_W);

    typedef struct packed {
        logic pend;
        logic act;
    } irq_state_t;

    function automatic logic preempts(input prio_t p, input level_t lvl);
        return {1'b0, p} < lvl;
    endfunction

endpackage

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_i,
    input  logic       set_i,
    input  logic       clr_i,
    input  logic       enter_i,
    input  logic       leave_i,
    output irq_state_t st_o
);

    irq_state_t st_q, st_n;
    logic       line_q;
    logic       rise, raise;

    always_comb begin
        st_n.act = enter_i ? 1'b1 : (leave_i ? 1'b0 : st_q.act);
        rise     = line_i & ~line_q;
        raise    = set_i | rise | (line_i & ~st_n.act);
        if (enter_i)
            st_n.pend = 1'b0;
        else if (raise)
            st_n.pend = 1'b1;
        else if (clr_i && !line_i)
            st_n.pend = 1'b0;
        else
            st_n.pend = st_q.pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            line_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            line_q <= line_i;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/irq_min_pick.sv
module irq_min_pick
    import irq_pkg::*;
#(
    parameter int N     = 41,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]        mask_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    output logic                found_o,
    output logic [IDX_W-1:0]    idx_o,
    output prio_t               prio_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = 0; i < N; i++) begin
            if (mask_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                prio_o  = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_pkg::*;
#(
    parameter int N_IRQ = 41,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_IRQ-1:0]          irq_line,
    input  logic [N_IRQ-1:0]          irq_en,
    input  logic [N_IRQ*PRIO_W-1:0]   irq_prio,
    input  logic [N_IRQ-1:0]          sw_set,
    input  logic [N_IRQ-1:0]          sw_clr,
    input  logic                      ack_valid,
    input  logic [IDX_W-1:0]          ack_idx,
    input  logic                      ret_valid,
    output logic                      req_valid,
    output logic [IDX_W-1:0]          req_idx,
    output logic [N_IRQ-1:0]          pend_o,
    output logic [N_IRQ-1:0]          act_o
);

    irq_state_t [N_IRQ-1:0] st;
    logic [N_IRQ-1:0]       cand;
    logic                   req_found, run_found;
    logic [IDX_W-1:0]       run_idx;
    prio_t                  req_prio, run_prio;
    level_t                 cur_level;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        logic enter, leave;
        assign enter = ack_valid && (ack_idx == IDX_W'(i));
        assign leave = ret_valid && run_found && (run_idx == IDX_W'(i));

        irq_line_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .line_i  (irq_line[i]),
            .set_i   (sw_set[i]),
            .clr_i   (sw_clr[i]),
            .enter_i (enter),
            .leave_i (leave),
            .st_o    (st[i])
        );

        assign pend_o[i] = st[i].pend;
        assign act_o[i]  = st[i].act;
    end

    assign cand = pend_o & irq_en & ~act_o;

    irq_min_pick #(.N(N_IRQ), .IDX_W(IDX_W)) u_pick_req (
        .mask_i  (cand),
        .prio_i  (irq_prio),
        .found_o (req_found),
        .idx_o   (req_idx),
        .prio_o  (req_prio)
    );

    irq_min_pick #(.N(N_IRQ), .IDX_W(IDX_W)) u_pick_run (
        .mask_i  (act_o),
        .prio_i  (irq_prio),
        .found_o (run_found),
        .idx_o   (run_idx),
        .prio_o  (run_prio)
    );

    assign cur_level = run_found ? {1'b0, run_prio} : LEVEL_IDLE;
    assign req_valid = req_found && preempts(req_prio, cur_level);

endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
    import irq_pkg::*;
#(
    parameter int N_IRQ = 41,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input logic                    clk,
    input logic                    rst,
    input logic [N_IRQ-1:0]        irq_line,
    input logic [N_IRQ-1:0]        irq_en,
    input logic [N_IRQ*PRIO_W-1:0] irq_prio,
    input logic [N_IRQ-1:0]        sw_set,
    input logic [N_IRQ-1:0]        sw_clr,
    input logic                    ack_valid,
    input logic [IDX_W-1:0]        ack_idx,
    input logic                    ret_valid,
    input logic                    req_valid,
    input logic [IDX_W-1:0]        req_idx,
    input logic [N_IRQ-1:0]        pend_o,
    input logic [N_IRQ-1:0]        act_o
);

    function automatic prio_t prio_of(input int k);
        return irq_prio[k*PRIO_W +: PRIO_W];
    endfunction

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (pend_o == '0 && act_o == '0 && !req_valid));

    p_entry_active_r6: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> (act_o[$past(ack_idx)] && !pend_o[$past(ack_idx)]));

    p_req_candidate_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (pend_o[req_idx] && !act_o[req_idx]));

    p_req_enabled_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> irq_en[req_idx]);

    for (genvar i = 0; i < N_IRQ; i++) begin : g_chk
        logic entering;
        assign entering = ack_valid && (ack_idx == IDX_W'(i));

        p_level_pends_r2: assert property (@(posedge clk) disable iff (rst)
            (irq_line[i] && !act_o[i] && !entering) |=> pend_o[i]);

        p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
            (sw_set[i] && !entering) |=> pend_o[i]);

        p_clr_high_ignored_r5: assert property (@(posedge clk) disable iff (rst)
            (sw_clr[i] && irq_line[i] && pend_o[i] && !entering) |=> pend_o[i]);

        p_req_beats_level_r9: assert property (@(posedge clk) disable iff (rst)
            (req_valid && act_o[i]) |-> (prio_of(int'(req_idx)) < prio_of(i)));
    end

endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (.*);

// File: tb/tb_irq_level_ctrl.sv
`timescale 1ns/1ps
module tb_irq_level_ctrl;

    localparam int N  = 41;
    localparam int IW = $clog2(N);
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  line, en, sset, sclr;
    logic [N*PW-1:0] prio;
    logic          ack_v, ret_v;
    logic [IW-1:0] ack_i;
    logic          req_valid;
    logic [IW-1:0] req_idx;
    logic [N-1:0]  pend_o, act_o;

    logic [N-1:0]  pm, am, lp;
    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    irq_level_ctrl #(.N_IRQ(N)) dut (
        .clk(clk), .rst(rst), .irq_line(line), .irq_en(en), .irq_prio(prio),
        .sw_set(sset), .sw_clr(sclr), .ack_valid(ack_v), .ack_idx(ack_i),
        .ret_valid(ret_v), .req_valid(req_valid), .req_idx(req_idx),
        .pend_o(pend_o), .act_o(act_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int p(input int k);
        return int'(prio[k*PW +: PW]);
    endfunction

    // Expected request from the model state (R8, R9, R10)
    task automatic exp_req(output logic v, output int idx);
        int best = -1;
        int lvl  = 16;
        for (int i = 0; i < N; i++)
            if (pm[i] && en[i] && !am[i] && (best < 0 || p(i) < p(best))) best = i;
        for (int i = 0; i < N; i++)
            if (am[i] && p(i) < lvl) lvl = p(i);
        v   = (best >= 0) && (p(best) < lvl);
        idx = (best < 0) ? 0 : best;
    endtask

    // Advance the model across one rising edge with the present inputs
    task automatic model_step();
        logic [N-1:0] pn, an;
        int run = -1;
        if (rst) begin
            pm = '0; am = '0; lp = '0;
            return;
        end
        for (int i = 0; i < N; i++)
            if (am[i] && (run < 0 || p(i) < p(run))) run = i;
        for (int i = 0; i < N; i++) begin
            logic ent, lv, rise, raise;
            ent  = ack_v && (int'(ack_i) == i);
            lv   = ret_v && (run == i);
            an[i] = ent ? 1'b1 : (lv ? 1'b0 : am[i]);
            rise = line[i] && !lp[i];
            raise = sset[i] || rise || (line[i] && !an[i]);
            if (ent) pn[i] = 1'b0;
            else if (raise) pn[i] = 1'b1;
            else if (sclr[i] && !line[i]) pn[i] = 1'b0;
            else pn[i] = pm[i];
        end
        pm = pn; am = an; lp = line;
    endtask

    task automatic compare_all();
        logic v;
        int idx;
        exp_req(v, idx);
        chk("R2 R3 R4 R5 R7 pending", 64'(pend_o), 64'(pm));
        chk("R6 R7 active", 64'(act_o), 64'(am));
        chk("R9 R11 req_valid", 64'(req_valid), 64'(v));
        if (v) chk("R8 req_idx", 64'(req_idx), 64'(idx));
    endtask

    // Inputs are set at a falling edge; this crosses one rising edge
    task automatic tick();
        model_step();
        @(negedge clk);
        compare_all();
        sset = '0; sclr = '0; ack_v = 1'b0; ret_v = 1'b0;
    endtask

    task automatic setp(input int k, input int v);
        prio[k*PW +: PW] = PW'(v);
    endtask

    initial begin
        void'($urandom(32'd20240917));
        rst = 1'b1; line = '1; en = '1; sset = '0; sclr = '0;
        ack_v = 1'b0; ack_i = '0; ret_v = 1'b0;
        prio = '0;
        for (int i = 0; i < N; i++) setp(i, 8);
        @(negedge clk);
        tick(); tick();
        chk("R1 pend after reset", 64'(pend_o), 64'd0);
        chk("R1 act after reset", 64'(act_o), 64'd0);
        chk("R1 req after reset", 64'(req_valid), 64'd0);
        rst = 1'b0; line = '0;
        tick();

        // R3: short pulse latched
        line[5] = 1'b1; tick();
        chk("R2 level pends", 64'(pend_o[5]), 64'd1);
        line[5] = 1'b0; tick(); tick();
        chk("R3 latched after drop", 64'(pend_o[5]), 64'd1);
        chk("R8 single winner", 64'(req_idx), 64'd5);

        // R5: clear with line low
        sclr[5] = 1'b1; tick();
        chk("R5 clear low", 64'(pend_o[5]), 64'd0);

        // R5: clear while high ignored
        line[7] = 1'b1; tick();
        sclr[7] = 1'b1; tick();
        chk("R5 clear high ignored", 64'(pend_o[7]), 64'd1);

        // R4: set and clear together
        sset[9] = 1'b1; sclr[9] = 1'b1; tick();
        chk("R4 set wins", 64'(pend_o[9]), 64'd1);
        chk("R8 tie lowest index", 64'(req_idx), 64'd7);

        // R11: priority change without an edge
        setp(9, 3); #1;
        chk("R11 prio same cycle", 64'(req_idx), 64'd9);
        @(negedge clk); compare_all();

        // R6 and R9
        ack_v = 1'b1; ack_i = IW'(9); tick();
        chk("R6 entered active", 64'(act_o[9]), 64'd1);
        chk("R6 entered not pending", 64'(pend_o[9]), 64'd0);
        chk("R9 no preempt lower urgency", 64'(req_valid), 64'd0);
        setp(7, 3); #1;
        chk("R9 equal does not preempt", 64'(req_valid), 64'd0);
        setp(7, 2); #1;
        chk("R9 strictly lower preempts", 64'(req_valid), 64'd1);
        setp(7, 8);
        @(negedge clk); compare_all();

        // R7: return with line low
        ret_v = 1'b1; tick();
        chk("R7 return low idle act", 64'(act_o[9]), 64'd0);
        chk("R7 return low idle pend", 64'(pend_o[9]), 64'd0);

        // R7: return with line high repends
        ack_v = 1'b1; ack_i = IW'(7); tick();
        chk("R2 active line not repended", 64'(pend_o[7]), 64'd0);
        ret_v = 1'b1; tick();
        chk("R7 return high repends", 64'(pend_o[7]), 64'd1);
        chk("R7 return high leaves active", 64'(act_o[7]), 64'd0);

        // R10: disabled
        en[7] = 1'b0; #1;
        chk("R10 disabled no request", 64'(req_valid), 64'd0);
        @(negedge clk); compare_all();
        chk("R10 disabled keeps pending", 64'(pend_o[7]), 64'd1);
        en[7] = 1'b1; line[7] = 1'b0; sclr[7] = 1'b1; tick();

        // Constrained random phase
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(15) == 0) line[i] = ~line[i];
                sset[i] = ($urandom_range(63) == 0);
                sclr[i] = ($urandom_range(31) == 0);
                if ($urandom_range(199) == 0) setp(i, int'($urandom_range(15)));
                if ($urandom_range(299) == 0) en[i] = ~en[i];
            end
            #1;
            if (req_valid && $urandom_range(1) == 1) begin
                ack_v = 1'b1; ack_i = req_idx;
            end else if (act_o != '0 && $urandom_range(3) == 0) begin
                ret_v = 1'b1;
            end
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule